// File: doc/BRIEF.md
# Paged Address Translator with Access Checking

This block sits between a processor's address bus and main memory. It maps every logical address inside the low 4 MiB RAM window to a physical address. It does this through a table of 1024 page descriptors, each covering 4 KiB. In the same cycle it classifies the access as allowed, page fault, kernel-space violation or write-protect violation. A bus-error path elsewhere in the chip acts on that status.

The processor privilege level and a flag marking DMA cycles come in with each access. Descriptors are loaded through a synchronous write port. The lookup itself is purely combinational on the current table contents. Addresses above the RAM window are passed through unchanged and always reported as allowed, because region decoding for ROM and I/O is done elsewhere.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset every descriptor reads as zero, so any access inside the window reports status 2'b01 (page fault) until a descriptor is written.
- R2: A descriptor presented on the write port with `map_we` high is stored at the rising clock edge and governs lookups from then on. Descriptor layout: bit 15 = page present, bit 14 = writable, bits 9:0 = physical page number.
- R3: Inside the window, `phys_addr` is `{2'b00, physical page, acc_addr[11:0]}`, where the page is selected by `acc_addr[21:12]`.
- R4: When `acc_super` or `acc_dma` is high, no kernel or write-protect status is ever produced; a present page reports 2'b00.
- R5: A user access (`acc_super` and `acc_dma` low) to a present page with `acc_addr[22:19]` all zero reports 2'b10. The exception is the case in R6.
- R6: A user read at an address at or below 0x001000 is exempt from the kernel check. Addresses 0x000000 through 0x001000 are allowed; 0x001001 is not.
- R7: A user write to a present page outside kernel space whose writable bit is clear reports 2'b11. A read of that page, or a write once the bit is set, reports 2'b00.
- R8: The page-fault status 2'b01 (present bit clear) takes priority over every other status, for all privilege levels and DMA.
- R9: For addresses at or above 0x400000 (`acc_addr[23:22]` nonzero), `phys_addr` equals `acc_addr` and the status is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_addr | input | 24 | Logical byte address of the current access |
| acc_wr | input | 1 | High for a write access |
| acc_super | input | 1 | High when the processor runs privileged |
| acc_dma | input | 1 | High for a DMA cycle |
| map_we | input | 1 | Descriptor write strobe |
| map_idx | input | 10 | Descriptor index to write |
| map_wdata | input | 16 | Descriptor value to write |
| phys_addr | output | 24 | Translated (or passed-through) address |
| acc_status | output | 2 | 00 allowed, 01 page fault, 10 kernel violation, 11 write-protect |

## Verification
The properties assume the access inputs carry known values at every clock edge after reset release. They also assume that a lookup in the cycle after a descriptor write is meant to see the new entry. A write and a lookup of the same page in one cycle are expected to see the old entry. The stimulus changes inputs only on the falling edge. It issues descriptor writes only after the internal reset has released, and it concentrates addresses near the 0x001000 boundary, in the kernel region and above the window, so that each status branch is exercised.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_ABSENT = 2'b01,
    ST_KERNEL = 2'b10,
    ST_WPROT  = 2'b11
  } acc_st_e;

  localparam int unsigned DESC_PRESENT_BIT = 15;
  localparam int unsigned DESC_WREN_BIT    = 14;
endpackage

// File: rtl/pxu_rst_sync.sv
`timescale 1ns/1ps
module pxu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pxu_map_store.sv
`timescale 1ns/1ps
module pxu_map_store #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] ent_en;
  logic [ENT_W-1:0] ent_arr [DEPTH];

  // one-hot clock enable per descriptor
  always_comb begin
    ent_en = '0;
    if (wr_en) ent_en[wr_idx] = 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (ent_en[g]) q <= wr_data;
    end
    assign ent_arr[g] = q;
  end

  assign rd_data = ent_arr[rd_idx];
endmodule

// File: rtl/pxu_xlate.sv
`timescale 1ns/1ps
module pxu_xlate #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] lg_addr,
  input  logic [IDX_W-1:0]  ppn,
  output logic              in_win,
  output logic [IDX_W-1:0]  pg_idx,
  output logic [ADDR_W-1:0] ph_addr
);
  localparam int unsigned WIN_TOP = IDX_W + OFF_W;

  logic [ADDR_W-1:0] mapped;

  assign in_win = ~|lg_addr[ADDR_W-1:WIN_TOP];
  assign pg_idx = lg_addr[WIN_TOP-1:OFF_W];

  always_comb begin
    mapped                 = '0;
    mapped[WIN_TOP-1:OFF_W] = ppn;
    mapped[OFF_W-1:0]       = lg_addr[OFF_W-1:0];
  end

  assign ph_addr = in_win ? mapped : lg_addr;
endmodule

// File: rtl/pxu_perm.sv
`timescale 1ns/1ps
module pxu_perm
  import pxu_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 24,
  parameter int unsigned        KZ_LO       = 19,
  parameter int unsigned        KZ_HI       = 22,
  parameter logic [ADDR_W-1:0]  LOW_RD_MAX  = 24'h001000
) (
  input  logic              in_win,
  input  logic [ADDR_W-1:0] lg_addr,
  input  logic              is_wr,
  input  logic              is_super,
  input  logic              is_dma,
  input  logic              pg_present,
  input  logic              pg_wren,
  output acc_st_e           status
);
  logic kern_zone;
  logic low_rd_ok;
  logic priv;

  assign kern_zone = ~|lg_addr[KZ_HI:KZ_LO];
  assign low_rd_ok = !is_wr && (lg_addr <= LOW_RD_MAX);
  assign priv      = is_super | is_dma;

  // fixed priority: window, presence, privilege, kernel, write-protect
  always_comb begin
    if (!in_win)                      status = ST_OK;
    else if (!pg_present)             status = ST_ABSENT;
    else if (priv)                    status = ST_OK;
    else if (kern_zone && !low_rd_ok) status = ST_KERNEL;
    else if (is_wr && !pg_wren)       status = ST_WPROT;
    else                              status = ST_OK;
  end
endmodule

// File: rtl/page_xlate_unit.sv
`timescale 1ns/1ps
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ENT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_super,
  input  logic              acc_dma,
  input  logic              map_we,
  input  logic [IDX_W-1:0]  map_idx,
  input  logic [ENT_W-1:0]  map_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [1:0]        acc_status
);
  logic             srst_n;
  logic             in_win;
  logic [IDX_W-1:0] pg_idx;
  logic [ENT_W-1:0] desc;
  acc_st_e          st;

  pxu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pxu_map_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_map (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (map_we),
    .wr_idx  (map_idx),
    .wr_data (map_wdata),
    .rd_idx  (pg_idx),
    .rd_data (desc)
  );

  pxu_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_xl (
    .lg_addr (acc_addr),
    .ppn     (desc[IDX_W-1:0]),
    .in_win  (in_win),
    .pg_idx  (pg_idx),
    .ph_addr (phys_addr)
  );

  pxu_perm #(.ADDR_W(ADDR_W)) u_perm (
    .in_win     (in_win),
    .lg_addr    (acc_addr),
    .is_wr      (acc_wr),
    .is_super   (acc_super),
    .is_dma     (acc_dma),
    .pg_present (desc[DESC_PRESENT_BIT]),
    .pg_wren    (desc[DESC_WREN_BIT]),
    .status     (st)
  );

  assign acc_status = st;
endmodule

// File: rtl/page_xlate_chk.sv
`timescale 1ns/1ps
module page_xlate_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ENT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wr,
  input logic              acc_super,
  input logic              acc_dma,
  input logic              map_we,
  input logic [IDX_W-1:0]  map_idx,
  input logic [ENT_W-1:0]  map_wdata,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [1:0]        acc_status
);
  localparam int unsigned WIN_TOP = IDX_W + OFF_W;

  logic win;
  logic user;
  logic kz;
  assign win  = (acc_addr[ADDR_W-1:WIN_TOP] == '0);
  assign user = !acc_super && !acc_dma;
  assign kz   = (acc_addr[22:19] == 4'b0000);

  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> (phys_addr[OFF_W-1:0] == acc_addr[OFF_W-1:0]) &&
            (phys_addr[ADDR_W-1:WIN_TOP] == '0));

  p_map_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(map_we) && win &&
     ($past(map_idx) == acc_addr[WIN_TOP-1:OFF_W]) && acc_status != 2'b01)
    |-> (phys_addr[WIN_TOP-1:OFF_W] == $past(map_wdata[IDX_W-1:0])));

  p_priv_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_super || acc_dma) |-> (acc_status == 2'b00 || acc_status == 2'b01));

  p_kernel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win && user && kz && (acc_wr || acc_addr > 24'h001000) && acc_status != 2'b01)
    |-> acc_status == 2'b10);

  p_low_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (user && !acc_wr && acc_addr <= 24'h001000) |-> acc_status != 2'b10);

  p_wprot_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr) |-> acc_status != 2'b11);

  p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win) |-> (acc_status == 2'b00 && phys_addr == acc_addr));
endmodule

bind page_xlate_unit page_xlate_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .acc_addr   (acc_addr),
  .acc_wr     (acc_wr),
  .acc_super  (acc_super),
  .acc_dma    (acc_dma),
  .map_we     (map_we),
  .map_idx    (map_idx),
  .map_wdata  (map_wdata),
  .phys_addr  (phys_addr),
  .acc_status (acc_status)
);

// File: tb/sim_page_xlate_unit.sv
`timescale 1ns/1ps
module sim_page_xlate_unit;
  logic        clk;
  logic        rst_n;
  logic [23:0] acc_addr;
  logic        acc_wr, acc_super, acc_dma;
  logic        map_we;
  logic [9:0]  map_idx;
  logic [15:0] map_wdata;
  logic [23:0] phys_addr;
  logic [1:0]  acc_status;

  logic [15:0] mdl [1024];
  int n_vec;
  int n_bad;
  bit done;

  page_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_super(acc_super), .acc_dma(acc_dma), .map_we(map_we),
    .map_idx(map_idx), .map_wdata(map_wdata), .phys_addr(phys_addr),
    .acc_status(acc_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected {status, phys} from the requirements
  function automatic logic [25:0] expect_of(input logic [23:0] a, input logic w,
                                            input logic s, input logic d);
    logic [15:0] e;
    logic [1:0]  st;
    logic [23:0] p;
    if (a[23:22] != 2'b00) return {2'b00, a};                       // R9
    e = mdl[a[21:12]];
    p = {2'b00, e[9:0], a[11:0]};                                    // R3
    if (!e[15])                              st = 2'b01;             // R8
    else if (s || d)                         st = 2'b00;             // R4
    else if (a[22:19] == 4'b0 && !(!w && a <= 24'h001000)) st = 2'b10; // R5 R6
    else if (w && !e[14])                    st = 2'b11;             // R7
    else                                     st = 2'b00;
    return {st, p};
  endfunction

  task automatic put_desc(input logic [9:0] idx, input logic [15:0] val);
    @(negedge clk);
    map_we = 1'b1; map_idx = idx; map_wdata = val;
    @(posedge clk);
    #1;
    map_we = 1'b0;
    mdl[idx] = val;
  endtask

  task automatic probe(input logic [23:0] a, input logic w, input logic s,
                       input logic d, input string req);
    logic [25:0] ex;
    @(negedge clk);
    acc_addr = a; acc_wr = w; acc_super = s; acc_dma = d;
    #1;
    ex = expect_of(a, w, s, d);
    n_vec++;
    if ({acc_status, phys_addr} !== ex) begin
      n_bad++;
      $display("FAIL %s addr=%h wr=%0b sup=%0b dma=%0b actual st=%b pa=%h expected st=%b pa=%h",
               req, a, w, s, d, acc_status, phys_addr, ex[25:24], ex[23:0]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_vec = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 1024; i++) mdl[i] = 16'h0000;
    rst_n = 1'b0; acc_addr = '0; acc_wr = 0; acc_super = 0; acc_dma = 0;
    map_we = 0; map_idx = '0; map_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: empty table after reset
    probe(24'h003456, 1'b0, 1'b1, 1'b0, "R1");
    probe(24'h3FF000, 1'b1, 1'b0, 1'b1, "R1");

    // R2 / R3: load and translate
    put_desc(10'd5, 16'hC2A5);
    probe(24'h005ABC, 1'b0, 1'b1, 1'b0, "R2");
    put_desc(10'd5, 16'h8011);
    probe(24'h005001, 1'b0, 1'b1, 1'b0, "R2");
    put_desc(10'd0,   16'h8100);
    put_desc(10'd1,   16'h8101);
    put_desc(10'd2,   16'h8102);
    put_desc(10'd256, 16'h8200);   // 0x100000, outside kernel region, read-only
    put_desc(10'd257, 16'hC201);   // writable
    probe(24'h100FFF, 1'b0, 1'b0, 1'b0, "R3");

    // R4: privilege bypass
    probe(24'h000800, 1'b1, 1'b1, 1'b0, "R4");
    probe(24'h100010, 1'b1, 1'b0, 1'b1, "R4");
    probe(24'h002004, 1'b1, 1'b0, 1'b1, "R4");

    // R5: user kernel-space accesses
    probe(24'h000800, 1'b1, 1'b0, 1'b0, "R5");
    probe(24'h002000, 1'b0, 1'b0, 1'b0, "R5");

    // R6: low read boundary
    probe(24'h000000, 1'b0, 1'b0, 1'b0, "R6");
    probe(24'h001000, 1'b0, 1'b0, 1'b0, "R6");
    probe(24'h001001, 1'b0, 1'b0, 1'b0, "R6");
    probe(24'h001000, 1'b1, 1'b0, 1'b0, "R6");

    // R7: write protect
    probe(24'h100020, 1'b1, 1'b0, 1'b0, "R7");
    probe(24'h100020, 1'b0, 1'b0, 1'b0, "R7");
    probe(24'h101020, 1'b1, 1'b0, 1'b0, "R7");

    // R8: absent page beats everything
    probe(24'h004000, 1'b1, 1'b0, 1'b0, "R8");
    probe(24'h180000, 1'b0, 1'b0, 1'b1, "R8");

    // R9: above window
    probe(24'h400000, 1'b1, 1'b0, 1'b0, "R9");
    probe(24'hFFFFFF, 1'b0, 1'b0, 1'b0, "R9");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] a;
      int sel;
      if ($urandom_range(3) == 0) begin
        logic [9:0] ix;
        logic [15:0] v;
        ix = ($urandom_range(1) == 0) ? 10'($urandom_range(7)) : 10'($urandom);
        if ($urandom_range(1) == 0) ix = 10'd256 + 10'($urandom_range(7));
        v = 16'($urandom);
        put_desc(ix, v);
      end
      sel = $urandom_range(4);
      case (sel)
        0: a = 24'h000FF0 + 24'($urandom_range(32));
        1: a = 24'($urandom_range(24'h07FFFF));
        2: a = 24'h100000 + 24'($urandom_range(24'h7FFF));
        3: a = 24'($urandom_range(24'h3FFFFF));
        default: a = 24'($urandom);
      endcase
      probe(a, 1'($urandom), ($urandom_range(3) == 0), ($urandom_range(5) == 0), "R3");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule